// File: doc/BRIEF.md
# Multiprocessor UART with Address Filtering

This block is an asynchronous serial port for nodes that share one line in a master/slave arrangement. It sends and receives frames made of a start bit, eight data bits sent least significant bit first, an optional ninth bit, and a stop bit. A two-bit format selector picks the frame. Format 01 is an 8-bit frame timed by the external 16x tick. Format 10 is a 9-bit frame timed by an internal fixed divider of the clock. Format 11 is a 9-bit frame timed by the external 16x tick. Format 00 is reserved, and both shifters stay idle while it is selected.

A slave node normally runs with address filtering turned on. Its receive-done flag is then raised only for frames that carry an address that concerns the node: either its own address, in which mask bits pick the positions that must match, or the broadcast pattern. In the 9-bit formats the ninth bit marks an address frame. The done, receive-done and framing-error flags are sticky. A set request takes priority over a clear pulse in the same cycle.

Top module: `mpuart`

## Requirements
- R1: After reset, txd is 1, and tx_done, rx_done, frame_err, rx_data and rx_bit9 are all 0.
- R2: A transmitted frame drives txd with a 0 start bit, then tx_data least significant bit first, then tx_bit9 when mode[1] is 1, then a 1 stop bit. Each bit lasts 16 tick16 pulses in formats 01 and 11, and 16*FIX_DIV clock cycles in format 10.
- R3: tx_done rises on the same clock edge on which txd enters the stop bit. It stays set until a clr_txdone pulse.
- R4: A tx_start pulse received while a frame is being sent, or while mode is 00, changes nothing on txd.
- R5: A frame received on rxd is assembled least significant bit first. rx_done is set when the middle of the stop bit is sampled, and it stays set until clr_rxdone.
- R6: When a frame is accepted, rx_bit9 takes the received ninth bit in formats 10 and 11. In format 01 it takes the stop-bit value.
- R7: In formats 10 and 11 with addr_filt_en at 1, a frame is accepted only if its ninth bit is 1 and its byte hits the address.
- R8: In format 01 with addr_filt_en at 1, a frame is accepted only if its stop bit is 1 and its byte hits the address. With addr_filt_en at 0, every completed frame is accepted.
- R9: A byte b hits the address when ((b ^ local_addr) & addr_mask) == 0 (own address, mask bit 0 means don't care), or when (b & (local_addr | addr_mask)) == (local_addr | addr_mask) (broadcast).
- R10: frame_err is set whenever a stop bit is sampled as 0, whether or not the frame is accepted. A later valid frame does not clear it; only clr_ferr does.
- R11: While rx_en is 0, a frame on rxd sets no flag and leaves rx_data unchanged.
- R12: A low pulse on rxd that is high again at the middle of the start bit is dropped, and the next proper frame is received correctly. Each bit value is a 2-of-3 vote over the samples at ticks 7, 8 and 9 of its 16.
- R13: A frame that is not accepted leaves rx_data and rx_bit9 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | 16x bit-rate enable for formats 01 and 11 |
| mode | input | 2 | Frame format selector |
| addr_filt_en | input | 1 | Address filtering enable |
| rx_en | input | 1 | Receive enable |
| tx_start | input | 1 | Pulse that starts a transmission |
| tx_data | input | 8 | Byte to send |
| tx_bit9 | input | 1 | Ninth bit to send in the 9-bit formats |
| local_addr | input | 8 | Node address |
| addr_mask | input | 8 | Address mask, 0 = don't care |
| rxd | input | 1 | Serial input |
| clr_txdone | input | 1 | Clears tx_done |
| clr_rxdone | input | 1 | Clears rx_done |
| clr_ferr | input | 1 | Clears frame_err |
| txd | output | 1 | Serial output, idles high |
| rx_data | output | 8 | Last accepted byte |
| rx_bit9 | output | 1 | Ninth bit or stop bit of the last accepted frame |
| tx_done | output | 1 | Sticky transmit-done flag |
| rx_done | output | 1 | Sticky receive-done flag |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
Each transmitted bit starts within one tick period of the edge that captured tx_start, so the bench samples txd at the middle of each bit. It reads tx_done at the middle of the last data bit, where it must be 0, and at the middle of the stop bit, where it must be 1. Receive results are due two synchronizer cycles after the vote at tick 9 of the stop bit. The bench therefore reads rx_done, rx_data, rx_bit9 and frame_err only after the whole stop bit plus eight cycles, and always before the next start edge. Address acceptance is swept over many bytes and ninth-bit values in each format, and the expected result is computed from the address arithmetic of the requirements.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;

  typedef enum logic [1:0] {
    FMT_OFF = 2'b00,
    FMT_8V  = 2'b01,
    FMT_9F  = 2'b10,
    FMT_9V  = 2'b11
  } fmt_e;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_st_e;

endpackage

// File: rtl/mpuart_tx.sv
module mpuart_tx #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bt,
  input  logic          load,
  input  logic          nine,
  input  logic [DW-1:0] data,
  input  logic          bit9,
  output logic          txd,
  output logic          busy,
  output logic          stop_go
);
  localparam int TW = $clog2(OVS);
  localparam int FW = DW + 3;
  localparam int BW = $clog2(FW + 1);

  logic          busy_q, busy_d;
  logic [FW-1:0] sh_q, sh_d;
  logic [BW-1:0] bcnt_q, bcnt_d, last_q, last_d;
  logic [TW-1:0] tcnt_q, tcnt_d;

  always_comb begin
    busy_d  = busy_q;
    sh_d    = sh_q;
    bcnt_d  = bcnt_q;
    last_d  = last_q;
    tcnt_d  = tcnt_q;
    stop_go = 1'b0;
    if (!busy_q) begin
      if (load) begin
        busy_d = 1'b1;
        sh_d   = nine ? {1'b1, bit9, data, 1'b0} : {2'b11, data, 1'b0};
        bcnt_d = '0;
        tcnt_d = '0;
        last_d = nine ? BW'(DW + 2) : BW'(DW + 1);
      end
    end else if (bt) begin
      if (tcnt_q == TW'(OVS - 1)) begin
        tcnt_d = '0;
        if (bcnt_q == last_q) begin
          busy_d = 1'b0;
        end else begin
          bcnt_d = bcnt_q + 1'b1;
          sh_d   = {1'b1, sh_q[FW-1:1]};
          if (bcnt_q + 1'b1 == last_q) stop_go = 1'b1;
        end
      end else begin
        tcnt_d = tcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      bcnt_q <= '0;
      last_q <= '0;
      tcnt_q <= '0;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      bcnt_q <= bcnt_d;
      last_q <= last_d;
      tcnt_q <= tcnt_d;
    end
  end

  assign txd  = busy_q ? sh_q[0] : 1'b1;
  assign busy = busy_q;
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx import mpuart_pkg::*; #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bt,
  input  logic          en,
  input  logic          nine,
  input  logic          rxd_s,
  output logic          fin,
  output logic          stop_ok,
  output logic [DW-1:0] rx_byte,
  output logic          rx_b9
);
  localparam int TW = $clog2(OVS);
  localparam int FW = DW + 1;
  localparam int BW = $clog2(DW + 3);
  localparam logic [TW-1:0] S0 = TW'(OVS / 2 - 1);
  localparam logic [TW-1:0] S1 = TW'(OVS / 2);
  localparam logic [TW-1:0] S2 = TW'(OVS / 2 + 1);

  rx_st_e        st_q, st_d;
  logic          prev_q;
  logic [TW-1:0] tcnt_q, tcnt_d;
  logic [BW-1:0] bcnt_q, bcnt_d, last;
  logic [1:0]    ones_q, ones_d, sum;
  logic [FW-1:0] sh_q, sh_d;
  logic          vote;

  assign last = nine ? BW'(DW + 2) : BW'(DW + 1);
  assign sum  = ones_q + {1'b0, rxd_s};
  assign vote = (sum >= 2'd2);

  always_comb begin
    st_d   = st_q;
    tcnt_d = tcnt_q;
    bcnt_d = bcnt_q;
    ones_d = ones_q;
    sh_d   = sh_q;
    fin    = 1'b0;
    case (st_q)
      RX_IDLE: begin
        if (en && prev_q && !rxd_s) begin
          st_d   = RX_BUSY;
          tcnt_d = '0;
          bcnt_d = '0;
          ones_d = '0;
        end
      end
      RX_BUSY: begin
        if (!en) begin
          st_d = RX_IDLE;
        end else if (bt) begin
          if (tcnt_q == S0 || tcnt_q == S1) ones_d = sum;
          if (tcnt_q == S2) begin
            ones_d = '0;
            if (bcnt_q == '0) begin
              if (vote) st_d = RX_IDLE;
            end else if (bcnt_q == last) begin
              fin  = 1'b1;
              st_d = RX_IDLE;
            end else begin
              sh_d = {vote, sh_q[FW-1:1]};
            end
          end
          if (tcnt_q == TW'(OVS - 1)) begin
            tcnt_d = '0;
            bcnt_d = bcnt_q + 1'b1;
          end else begin
            tcnt_d = tcnt_q + 1'b1;
          end
        end
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      prev_q <= 1'b1;
      tcnt_q <= '0;
      bcnt_q <= '0;
      ones_q <= '0;
      sh_q   <= '0;
    end else begin
      st_q   <= st_d;
      prev_q <= rxd_s;
      tcnt_q <= tcnt_d;
      bcnt_q <= bcnt_d;
      ones_q <= ones_d;
      sh_q   <= sh_d;
    end
  end

  assign stop_ok = vote;
  assign rx_byte = nine ? sh_q[DW-1:0] : sh_q[DW:1];
  assign rx_b9   = sh_q[DW];
endmodule

// File: rtl/mpuart_amatch.sv
module mpuart_amatch #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] byte_in,
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] mask,
  output logic          hit
);
  logic [DW-1:0] bcast;
  logic          own_hit, bc_hit;

  assign bcast   = addr | mask;
  assign own_hit = ((byte_in ^ addr) & mask) == '0;
  assign bc_hit  = (~byte_in & bcast) == '0;
  assign hit     = own_hit | bc_hit;
endmodule

// File: rtl/mpuart.sv
module mpuart import mpuart_pkg::*; #(
  parameter int OVS     = 16,
  parameter int DW      = 8,
  parameter int FIX_DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic [1:0]    mode,
  input  logic          addr_filt_en,
  input  logic          rx_en,
  input  logic          tx_start,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_bit9,
  input  logic [DW-1:0] local_addr,
  input  logic [DW-1:0] addr_mask,
  input  logic          rxd,
  input  logic          clr_txdone,
  input  logic          clr_rxdone,
  input  logic          clr_ferr,
  output logic          txd,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit9,
  output logic          tx_done,
  output logic          rx_done,
  output logic          frame_err
);
  localparam int FDW = (FIX_DIV > 1) ? $clog2(FIX_DIV) : 1;

  fmt_e          fmt;
  logic          nine, active, bt, fix_tick;
  logic [1:0]    sync_q;
  logic          tx_busy, tx_stop_go;
  logic          rx_fin, rx_stop_ok, rx_b9_raw, addr_hit, rx_accept;
  logic [DW-1:0] rx_byte;
  logic          txdone_q, txdone_d, rxdone_q, rxdone_d, ferr_q, ferr_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic          rb9_q, rb9_d;

  assign fmt    = fmt_e'(mode);
  assign nine   = (fmt == FMT_9F) || (fmt == FMT_9V);
  assign active = (fmt != FMT_OFF);

  generate
    if (FIX_DIV > 1) begin : g_fdiv
      logic [FDW-1:0] fcnt_q, fcnt_d;
      assign fix_tick = (fcnt_q == FDW'(FIX_DIV - 1));
      always_comb fcnt_d = fix_tick ? '0 : fcnt_q + 1'b1;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fcnt_q <= '0;
        else        fcnt_q <= fcnt_d;
      end
    end else begin : g_fnodiv
      assign fix_tick = 1'b1;
    end
  endgenerate

  assign bt = (fmt == FMT_9F) ? fix_tick : (active & tick16);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rxd};
  end

  mpuart_tx #(.OVS(OVS), .DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_n), .bt(bt), .load(tx_start & active),
    .nine(nine), .data(tx_data), .bit9(tx_bit9),
    .txd(txd), .busy(tx_busy), .stop_go(tx_stop_go)
  );

  mpuart_rx #(.OVS(OVS), .DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_n), .bt(bt), .en(rx_en & active),
    .nine(nine), .rxd_s(sync_q[1]), .fin(rx_fin), .stop_ok(rx_stop_ok),
    .rx_byte(rx_byte), .rx_b9(rx_b9_raw)
  );

  mpuart_amatch #(.DW(DW)) u_am (
    .byte_in(rx_byte), .addr(local_addr), .mask(addr_mask), .hit(addr_hit)
  );

  always_comb begin
    rx_accept = rx_fin && (!addr_filt_en ||
                (nine ? (rx_b9_raw && addr_hit) : (rx_stop_ok && addr_hit)));
    txdone_d = clr_txdone ? 1'b0 : txdone_q;
    if (tx_stop_go) txdone_d = 1'b1;
    rxdone_d = clr_rxdone ? 1'b0 : rxdone_q;
    if (rx_accept) rxdone_d = 1'b1;
    ferr_d = clr_ferr ? 1'b0 : ferr_q;
    if (rx_fin && !rx_stop_ok) ferr_d = 1'b1;
    rdata_d = rx_accept ? rx_byte : rdata_q;
    rb9_d   = rx_accept ? (nine ? rx_b9_raw : rx_stop_ok) : rb9_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txdone_q <= 1'b0;
      rxdone_q <= 1'b0;
      ferr_q   <= 1'b0;
      rdata_q  <= '0;
      rb9_q    <= 1'b0;
    end else begin
      txdone_q <= txdone_d;
      rxdone_q <= rxdone_d;
      ferr_q   <= ferr_d;
      rdata_q  <= rdata_d;
      rb9_q    <= rb9_d;
    end
  end

  assign tx_done   = txdone_q;
  assign rx_done   = rxdone_q;
  assign frame_err = ferr_q;
  assign rx_data   = rdata_q;
  assign rx_bit9   = rb9_q;
endmodule

// File: rtl/mpuart_chk.sv
module mpuart_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          addr_filt_en,
  input logic          rx_en,
  input logic          clr_txdone,
  input logic          clr_rxdone,
  input logic          clr_ferr,
  input logic          txd,
  input logic          tx_busy,
  input logic          rx_accept,
  input logic [DW-1:0] rx_data,
  input logic          rx_bit9,
  input logic          tx_done,
  input logic          rx_done,
  input logic          frame_err
);
  // R1
  txd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);
  // R3
  txdone_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done && !clr_txdone |=> tx_done);
  // R5
  rxdone_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !clr_rxdone |=> rx_done);
  // R10
  ferr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err && !clr_ferr |=> frame_err);
  // R11
  rxdone_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) |-> $past(rx_en));
  // R13
  rxdata_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rx_accept) |-> $stable(rx_data) && $stable(rx_bit9));
  // R7
  rxb9_filt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_done) && mode[1] && addr_filt_en |-> rx_bit9);
endmodule

bind mpuart mpuart_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .addr_filt_en(addr_filt_en),
  .rx_en(rx_en), .clr_txdone(clr_txdone), .clr_rxdone(clr_rxdone),
  .clr_ferr(clr_ferr), .txd(txd), .tx_busy(tx_busy), .rx_accept(rx_accept),
  .rx_data(rx_data), .rx_bit9(rx_bit9), .tx_done(tx_done),
  .rx_done(rx_done), .frame_err(frame_err)
);

// File: tb/mpuart_tb.sv
module mpuart_tb;
  localparam int TDIV  = 3;
  localparam int BIT_V = 16 * TDIV;
  localparam int BIT_F = 16 * 4;
  localparam logic [7:0] LA = 8'h56;
  localparam logic [7:0] LM = 8'hF0;

  logic clk, rst_n, tick16, addr_filt_en, rx_en, tx_start, tx_bit9, rxd;
  logic clr_txdone, clr_rxdone, clr_ferr;
  logic [1:0] mode;
  logic [7:0] tx_data, local_addr, addr_mask, rx_data;
  logic txd, rx_bit9, tx_done, rx_done, frame_err;

  int nchk, nerr;
  logic [7:0] exp_d;
  logic       exp_b9;

  mpuart u_dut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .mode(mode),
    .addr_filt_en(addr_filt_en), .rx_en(rx_en), .tx_start(tx_start),
    .tx_data(tx_data), .tx_bit9(tx_bit9), .local_addr(local_addr),
    .addr_mask(addr_mask), .rxd(rxd), .clr_txdone(clr_txdone),
    .clr_rxdone(clr_rxdone), .clr_ferr(clr_ferr), .txd(txd),
    .rx_data(rx_data), .rx_bit9(rx_bit9), .tx_done(tx_done),
    .rx_done(rx_done), .frame_err(frame_err)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  initial begin
    int tc;
    tc = 0;
    tick16 = 1'b0;
    forever begin
      @(negedge clk);
      tc = (tc + 1) % TDIV;
      tick16 = (tc == 0);
    end
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int bitc(input logic [1:0] m);
    return (m == 2'b10) ? BIT_F : BIT_V;
  endfunction

  task automatic clr_all();
    clr_txdone = 1'b1; clr_rxdone = 1'b1; clr_ferr = 1'b1;
    wclk(1);
    clr_txdone = 1'b0; clr_rxdone = 1'b0; clr_ferr = 1'b0;
  endtask

  task automatic send(input logic [7:0] d, input logic b9, input logic stopv);
    int bc;
    bc = bitc(mode);
    rxd = 1'b0; wclk(bc);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; wclk(bc); end
    if (mode[1]) begin rxd = b9; wclk(bc); end
    rxd = stopv; wclk(bc);
    rxd = 1'b1; wclk(8);
  endtask

  // Receive one frame and compare against the arithmetic model (R5 to R10, R13)
  task automatic rx_case(input logic [1:0] m, input logic filt,
                         input logic [7:0] d, input logic b9, input logic stopv);
    logic own, bc, hit, acc;
    mode = m; addr_filt_en = filt;
    clr_all();
    wclk(4);
    own = ((d ^ LA) & LM) == 8'h00;
    bc  = (d & (LA | LM)) == (LA | LM);
    hit = own | bc;
    acc = !filt || (m[1] ? (b9 && hit) : (stopv && hit));
    if (acc) begin
      exp_d  = d;
      exp_b9 = m[1] ? b9 : stopv;
    end
    send(d, b9, stopv);
    chk(rx_done == acc, m[1] ? "R5 R7 R9 rx_done" : "R5 R8 R9 rx_done", rx_done, acc);
    chk(rx_data == exp_d, "R5 R13 rx_data", rx_data, exp_d);
    chk(rx_bit9 == exp_b9, "R6 R13 rx_bit9", rx_bit9, exp_b9);
    chk(frame_err == !stopv, "R10 frame_err", frame_err, !stopv);
  endtask

  // Transmit one frame and sample txd mid-bit (R2, R3, R4)
  task automatic tx_case(input logic [1:0] m, input logic [7:0] d, input logic b9,
                         input bit poke);
    int bc, nb;
    logic e;
    mode = m; tx_data = d; tx_bit9 = b9;
    clr_all();
    wclk(2);
    bc = bitc(m);
    nb = m[1] ? 11 : 10;
    tx_start = 1'b1; wclk(1); tx_start = 1'b0;
    wclk(bc / 2);
    for (int k = 0; k < nb; k++) begin
      if (k == 0) e = 1'b0;
      else if (k <= 8) e = d[k-1];
      else if (k == 9 && m[1]) e = b9;
      else e = 1'b1;
      chk(txd == e, poke ? "R2 R4 txd bit" : "R2 txd bit", txd, e);
      if (k == nb - 2) chk(tx_done == 1'b0, "R3 tx_done before stop", tx_done, 0);
      if (k == nb - 1) chk(tx_done == 1'b1, "R3 tx_done at stop", tx_done, 1);
      if (poke && k == 1) begin
        tx_data = ~d; tx_start = 1'b1; wclk(1); tx_start = 1'b0; wclk(bc - 1);
        tx_data = d;
      end else begin
        wclk(bc);
      end
    end
    chk(txd == 1'b1, "R4 txd idle after frame", txd, 1);
    chk(tx_done == 1'b1, "R3 tx_done sticky", tx_done, 1);
    clr_txdone = 1'b1; wclk(1); clr_txdone = 1'b0;
    chk(tx_done == 1'b0, "R3 tx_done cleared", tx_done, 0);
  endtask

  initial begin
    nchk = 0; nerr = 0;
    wclk(190000);
    nerr++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 2'b01; addr_filt_en = 1'b0; rx_en = 1'b1;
    tx_start = 1'b0; tx_bit9 = 1'b0; tx_data = 8'h00; rxd = 1'b1;
    clr_txdone = 1'b0; clr_rxdone = 1'b0; clr_ferr = 1'b0;
    local_addr = LA; addr_mask = LM;
    exp_d = 8'h00; exp_b9 = 1'b0;
    wclk(5);
    rst_n = 1'b1;
    wclk(2);
    // R1
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk({tx_done, rx_done, frame_err} == 3'b000, "R1 flags", {tx_done, rx_done, frame_err}, 0);
    chk(rx_data == 8'h00, "R1 rx_data", rx_data, 0);
    chk(rx_bit9 == 1'b0, "R1 rx_bit9", rx_bit9, 0);

    // R2 R3 R4 transmit in each active format
    tx_case(2'b01, 8'hA5, 1'b0, 1'b0);
    tx_case(2'b11, 8'h3C, 1'b1, 1'b1);
    tx_case(2'b10, 8'h81, 1'b0, 1'b0);
    tx_case(2'b10, 8'h7E, 1'b1, 1'b1);
    // R4 reserved format ignores tx_start
    mode = 2'b00; tx_start = 1'b1; wclk(1); tx_start = 1'b0;
    for (int k = 0; k < 4; k++) begin
      wclk(BIT_V / 2);
      chk(txd == 1'b1, "R4 txd in format 00", txd, 1);
    end
    chk(tx_done == 1'b0, "R4 tx_done in format 00", tx_done, 0);

    // R6 R8 unfiltered 8-bit reception, including a bad stop bit
    rx_case(2'b01, 1'b0, 8'h5A, 1'b0, 1'b1);
    rx_case(2'b01, 1'b0, 8'hC3, 1'b0, 1'b0);
    // R10 frame_err survives a valid frame until cleared
    mode = 2'b01; addr_filt_en = 1'b0;
    send(8'h11, 1'b0, 1'b0);
    send(8'h22, 1'b0, 1'b1);
    chk(frame_err == 1'b1, "R10 frame_err sticky", frame_err, 1);
    exp_d = 8'h22; exp_b9 = 1'b1;
    clr_ferr = 1'b1; wclk(1); clr_ferr = 1'b0;
    chk(frame_err == 1'b0, "R10 frame_err cleared", frame_err, 0);

    // R8 R9 filtered 8-bit reception
    rx_case(2'b01, 1'b1, 8'h56, 1'b0, 1'b1);
    rx_case(2'b01, 1'b1, 8'h5F, 1'b0, 1'b0);
    rx_case(2'b01, 1'b1, 8'hF6, 1'b0, 1'b1);
    rx_case(2'b01, 1'b1, 8'h13, 1'b0, 1'b1);
    rx_case(2'b01, 1'b1, 8'hA6, 1'b0, 1'b1);
    rx_case(2'b01, 1'b1, 8'h50, 1'b0, 1'b1);

    // R7 R9 sweep in the variable-rate 9-bit format
    for (int i = 0; i < 40; i++) begin
      rx_case(2'b11, 1'b1, 8'((i * 37 + 5) % 256), (i % 5) != 0, 1'b1);
    end
    rx_case(2'b11, 1'b1, 8'hFF, 1'b1, 1'b1);
    rx_case(2'b11, 1'b1, 8'h5A, 1'b0, 1'b1);
    rx_case(2'b11, 1'b0, 8'h0F, 1'b0, 1'b1);

    // R6 R7 fixed-rate 9-bit format
    for (int i = 0; i < 10; i++) begin
      rx_case(2'b10, i < 6, 8'((i * 91 + 86) % 256), i[0], 1'b1);
    end

    // R11 receiver disabled
    mode = 2'b11; addr_filt_en = 1'b0; clr_all();
    rx_en = 1'b0;
    send(8'h99, 1'b1, 1'b1);
    chk(rx_done == 1'b0, "R11 rx_done while disabled", rx_done, 0);
    chk(rx_data == exp_d, "R11 rx_data while disabled", rx_data, exp_d);
    rx_en = 1'b1;
    wclk(4);

    // R12 short low glitch is dropped, next frame received
    rxd = 1'b0; wclk(6); rxd = 1'b1;
    wclk(BIT_V * 12);
    chk(rx_done == 1'b0, "R12 glitch rx_done", rx_done, 0);
    chk(frame_err == 1'b0, "R12 glitch frame_err", frame_err, 0);
    rx_case(2'b11, 1'b0, 8'hB4, 1'b1, 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule